// File: doc/BRIEF.md
# Paired Converter Slot Coordinator

This block sits between a shared slot sequencer and two converter control cores that must run in step. For each slot index the sequencer offers, it looks up a channel for each converter in two separate per-slot tables and starts both conversions in the same cycle. It then gathers the two responses in whichever order they come back and hands one combined result downstream. That result holds both 12-bit samples, both channel numbers, the slot index and the packet framing flags.

The second converter's table may mark a slot as empty. The second converter still runs a dummy conversion for that slot, so the two stay in step, but the combined result reports its sample as zero. The on-die temperature channel is wired only to the first converter, so any slot that selects it must be empty on the second. Only one slot pair is in flight at a time: the next slot is taken only after the combined result has been accepted.

Top module: `dual_conv_merger`

## Requirements
- R1: After reset, `slot_ready` is 1 and `cmd_a_valid`, `cmd_b_valid` and `out_valid` are 0.
- R2: A slot is taken on a cycle with `slot_valid` and `slot_ready` both 1. In the following cycle `cmd_a_valid` and `cmd_b_valid` are both 1.
- R3: `cmd_a_chan` is the first converter's table entry for the taken slot. `cmd_b_chan` is the second converter's table entry. The two tables are independent parameters, each holding CHAN_W bits per slot, with slot 0 in the lowest bits.
- R4: Each command valid stays at 1, with its channel unchanged, until that side's ready is seen. It then falls for that side alone.
- R5: A slot whose bit is set in NULL_MASK_B drives `cmd_b_chan` to the all-ones code. The combined result then reports `out_data_b` = 0, whatever the second converter returns. The first converter has no empty option: its command always carries its table entry.
- R6: A slot whose first-converter entry equals TEMP_CODE must have its NULL_MASK_B bit set. A configuration that breaks this is reported at time zero.
- R7: `out_valid` rises exactly two cycles after the later of the two responses is presented, whichever side comes last. It is 0 while either response is missing.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every result field stays stable.
- R9: The result carries the slot index, the slot's start and end flags, and the channel and data returned by each converter.
- R10: While a result is waiting, `slot_ready` is 0 and no command valid is raised, even with `slot_valid` held at 1. After `out_ready` is seen, `slot_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | 1 | Sequencer offers a slot |
| slot_ready | output | 1 | Block can take a slot |
| slot_idx | input | IDX_W | Slot index |
| slot_sop | input | 1 | Slot opens a sequence packet |
| slot_eop | input | 1 | Slot closes a sequence packet |
| cmd_a_valid | output | 1 | Command to first converter |
| cmd_a_ready | input | 1 | First converter takes command |
| cmd_a_chan | output | CHAN_W | First converter channel |
| cmd_b_valid | output | 1 | Command to second converter |
| cmd_b_ready | input | 1 | Second converter takes command |
| cmd_b_chan | output | CHAN_W | Second converter channel, all ones when empty |
| rsp_a_valid | input | 1 | First converter result strobe |
| rsp_a_chan | input | CHAN_W | First converter result channel |
| rsp_a_data | input | DATA_W | First converter sample |
| rsp_b_valid | input | 1 | Second converter result strobe |
| rsp_b_chan | input | CHAN_W | Second converter result channel |
| rsp_b_data | input | DATA_W | Second converter sample |
| out_valid | output | 1 | Combined result available |
| out_ready | input | 1 | Downstream takes the result |
| out_slot | output | IDX_W | Slot index of the result |
| out_sop | output | 1 | Start flag of the slot |
| out_eop | output | 1 | End flag of the slot |
| out_chan_a | output | CHAN_W | First converter channel |
| out_data_a | output | DATA_W | First converter sample |
| out_chan_b | output | CHAN_W | Second converter channel |
| out_data_b | output | DATA_W | Second converter sample, zero for an empty slot |

## Verification
A wrong pairing state shows up at once. If a done or captured flag is set too early or cleared too late, `out_valid` rises a cycle off the two-cycle point after the last response, or a side's command valid drops before its own ready. If the empty-slot flag is latched wrongly, the mistake appears in `cmd_b_chan` one cycle after the slot is taken and in `out_data_b` on the first result cycle. A state machine that leaves the result phase early raises `slot_ready` or a command valid while `out_valid` is still held.

// File: rtl/dcm_pkg.sv
// Shared types for the paired converter slot coordinator.
// Assumes: nothing beyond the package itself.
package dcm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_OUT  = 2'd2
    } dcm_state_e;
endpackage

// File: rtl/dcm_chan_lut.sv
// Per-slot channel lookup for one converter.
// Unpacks a flat parameter table into an array and selects by slot index.
// When HAS_NULL is set, also reports the slot's empty bit from NULL_MASK.
// Assumes: idx < N_SLOTS.
module dcm_chan_lut #(
    parameter int unsigned N_SLOTS  = 8,
    parameter int unsigned CHAN_W   = 5,
    parameter bit          HAS_NULL = 1'b0,
    parameter logic [N_SLOTS*CHAN_W-1:0] TABLE     = '0,
    parameter logic [N_SLOTS-1:0]        NULL_MASK = '0,
    localparam int unsigned IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CHAN_W-1:0] chan,
    output logic              is_null
);
    logic [CHAN_W-1:0] entry [N_SLOTS];

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_entry
        assign entry[s] = TABLE[s*CHAN_W +: CHAN_W];
    end

    assign chan = entry[idx];

    if (HAS_NULL) begin : g_null
        logic [N_SLOTS-1:0] mask_w;
        assign mask_w  = NULL_MASK;
        assign is_null = mask_w[idx];
    end else begin : g_no_null
        assign is_null = 1'b0;
    end
endmodule

// File: rtl/dcm_rsp_latch.sv
// Holds one converter's response for the current slot.
// Captures the first strobe seen while armed; clear empties it for a new slot.
// With FORCE_EN set, a captured sample is replaced by zero when force_zero is 1.
// Assumes: at most one response per issued command.
module dcm_rsp_latch #(
    parameter int unsigned CHAN_W   = 5,
    parameter int unsigned DATA_W   = 12,
    parameter bit          FORCE_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              arm,
    input  logic              force_zero,
    input  logic              rsp_valid,
    input  logic [CHAN_W-1:0] rsp_chan,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              got,
    output logic [CHAN_W-1:0] chan_q,
    output logic [DATA_W-1:0] data_q
);
    logic take;
    assign take = arm && rsp_valid && !got;

    // Presence flag: set on capture, dropped when a new slot begins.
    always_ff @(posedge clk) begin
        if (!rst_n)     got <= 1'b0;
        else if (clear) got <= 1'b0;
        else if (take)  got <= 1'b1;
    end

    // Channel register: loads with the captured response.
    always_ff @(posedge clk) begin
        if (!rst_n)    chan_q <= '0;
        else if (take) chan_q <= rsp_chan;
    end

    if (FORCE_EN) begin : g_force
        // Sample register with empty-slot substitution.
        always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (take) data_q <= force_zero ? '0 : rsp_data;
        end
    end else begin : g_plain
        logic unused_force;
        assign unused_force = force_zero;
        // Sample register without substitution.
        always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (take) data_q <= rsp_data;
        end
    end
endmodule

// File: rtl/dual_conv_merger.sv
// Paired converter slot coordinator.
// Takes one slot at a time, issues both converter commands in the same cycle,
// waits for both responses and presents them as one held result.
// Assumes: converters answer each command once, and never before it is taken.
module dual_conv_merger
    import dcm_pkg::*;
#(
    parameter int unsigned N_SLOTS   = 8,
    parameter int unsigned CHAN_W    = 5,
    parameter int unsigned DATA_W    = 12,
    parameter logic [CHAN_W-1:0] TEMP_CODE = 5'd17,
    parameter logic [N_SLOTS*CHAN_W-1:0] CHAN_TBL_A =
        {5'd16, 5'd2, 5'd8, 5'd5, 5'd0, 5'd3, 5'd17, 5'd1},
    parameter logic [N_SLOTS*CHAN_W-1:0] CHAN_TBL_B =
        {5'd0, 5'd4, 5'd1, 5'd8, 5'd0, 5'd3, 5'd0, 5'd2},
    parameter logic [N_SLOTS-1:0] NULL_MASK_B = 8'b0000_1010,
    localparam int unsigned IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid,
    output logic              slot_ready,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic              slot_sop,
    input  logic              slot_eop,
    output logic              cmd_a_valid,
    input  logic              cmd_a_ready,
    output logic [CHAN_W-1:0] cmd_a_chan,
    output logic              cmd_b_valid,
    input  logic              cmd_b_ready,
    output logic [CHAN_W-1:0] cmd_b_chan,
    input  logic              rsp_a_valid,
    input  logic [CHAN_W-1:0] rsp_a_chan,
    input  logic [DATA_W-1:0] rsp_a_data,
    input  logic              rsp_b_valid,
    input  logic [CHAN_W-1:0] rsp_b_chan,
    input  logic [DATA_W-1:0] rsp_b_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_slot,
    output logic              out_sop,
    output logic              out_eop,
    output logic [CHAN_W-1:0] out_chan_a,
    output logic [DATA_W-1:0] out_data_a,
    output logic [CHAN_W-1:0] out_chan_b,
    output logic [DATA_W-1:0] out_data_b
);
    localparam logic [CHAN_W-1:0] NULL_CODE = {CHAN_W{1'b1}};

    dcm_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sop_q, eop_q, null_q;
    logic [CHAN_W-1:0] chan_a_q, chan_b_q;
    logic              a_done_q, b_done_q;
    logic [CHAN_W-1:0] lut_a_chan, lut_b_chan;
    logic              lut_a_null, lut_b_null;
    logic              a_got, b_got;
    logic              accept, busy;

    assign accept = slot_valid && slot_ready;
    assign busy   = (state_q == ST_BUSY);

    dcm_chan_lut #(
        .N_SLOTS(N_SLOTS), .CHAN_W(CHAN_W), .HAS_NULL(1'b0),
        .TABLE(CHAN_TBL_A), .NULL_MASK('0)
    ) u_lut_a (
        .idx(slot_idx), .chan(lut_a_chan), .is_null(lut_a_null)
    );

    dcm_chan_lut #(
        .N_SLOTS(N_SLOTS), .CHAN_W(CHAN_W), .HAS_NULL(1'b1),
        .TABLE(CHAN_TBL_B), .NULL_MASK(NULL_MASK_B)
    ) u_lut_b (
        .idx(slot_idx), .chan(lut_b_chan), .is_null(lut_b_null)
    );

    logic unused_a_null;
    assign unused_a_null = lut_a_null;

    // Slot sequencing: idle -> both commands out -> result held -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) state_q <= ST_BUSY;
                ST_BUSY: if (a_done_q && b_done_q && a_got && b_got) state_q <= ST_OUT;
                ST_OUT:  if (out_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Slot context: captured once per taken slot and held until the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            sop_q    <= 1'b0;
            eop_q    <= 1'b0;
            null_q   <= 1'b0;
            chan_a_q <= '0;
            chan_b_q <= '0;
        end else if (accept) begin
            idx_q    <= slot_idx;
            sop_q    <= slot_sop;
            eop_q    <= slot_eop;
            null_q   <= lut_b_null;
            chan_a_q <= lut_a_chan;
            chan_b_q <= lut_b_null ? NULL_CODE : lut_b_chan;
        end
    end

    // Per-side command completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            a_done_q <= 1'b0;
            b_done_q <= 1'b0;
        end else begin
            if (cmd_a_valid && cmd_a_ready) a_done_q <= 1'b1;
            if (cmd_b_valid && cmd_b_ready) b_done_q <= 1'b1;
        end
    end

    assign slot_ready  = (state_q == ST_IDLE);
    assign cmd_a_valid = busy && !a_done_q;
    assign cmd_b_valid = busy && !b_done_q;
    assign cmd_a_chan  = chan_a_q;
    assign cmd_b_chan  = chan_b_q;

    dcm_rsp_latch #(.CHAN_W(CHAN_W), .DATA_W(DATA_W), .FORCE_EN(1'b0)) u_rsp_a (
        .clk(clk), .rst_n(rst_n), .clear(accept), .arm(busy), .force_zero(1'b0),
        .rsp_valid(rsp_a_valid), .rsp_chan(rsp_a_chan), .rsp_data(rsp_a_data),
        .got(a_got), .chan_q(out_chan_a), .data_q(out_data_a)
    );

    dcm_rsp_latch #(.CHAN_W(CHAN_W), .DATA_W(DATA_W), .FORCE_EN(1'b1)) u_rsp_b (
        .clk(clk), .rst_n(rst_n), .clear(accept), .arm(busy), .force_zero(null_q),
        .rsp_valid(rsp_b_valid), .rsp_chan(rsp_b_chan), .rsp_data(rsp_b_data),
        .got(b_got), .chan_q(out_chan_b), .data_q(out_data_b)
    );

    assign out_valid = (state_q == ST_OUT);
    assign out_slot  = idx_q;
    assign out_sop   = sop_q;
    assign out_eop   = eop_q;
endmodule

// File: rtl/dcm_checker.sv
// Property checks for the paired converter slot coordinator, bound to its top.
// Assumes: synchronous active-low reset on rst_n.
module dcm_checker #(
    parameter int unsigned N_SLOTS = 8,
    parameter int unsigned CHAN_W  = 5,
    parameter int unsigned DATA_W  = 12,
    parameter logic [CHAN_W-1:0] TEMP_CODE = 5'd17,
    parameter logic [N_SLOTS*CHAN_W-1:0] CHAN_TBL_A = '0,
    parameter logic [N_SLOTS-1:0] NULL_MASK_B = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_valid,
    input logic              slot_ready,
    input logic              cmd_a_valid,
    input logic              cmd_a_ready,
    input logic [CHAN_W-1:0] cmd_a_chan,
    input logic              cmd_b_valid,
    input logic              cmd_b_ready,
    input logic [CHAN_W-1:0] cmd_b_chan,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data_a,
    input logic [DATA_W-1:0] out_data_b,
    input logic              null_q
);
    function automatic bit pairing_broken();
        bit bad = 1'b0;
        for (int s = 0; s < int'(N_SLOTS); s++) begin
            if (CHAN_TBL_A[s*CHAN_W +: CHAN_W] == TEMP_CODE && !NULL_MASK_B[s])
                bad = 1'b1;
        end
        return bad;
    endfunction

    // R6: temperature slots on the first converter must be empty on the second.
    initial begin
        p_temp_pairing_r6: assert (!pairing_broken())
            else $error("temperature slot not empty on second converter");
    end

    // R1: reset leaves the block idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (slot_ready && !cmd_a_valid && !cmd_b_valid && !out_valid));

    // R2: a taken slot raises both commands together.
    p_lockstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_ready) |=> (cmd_a_valid && cmd_b_valid));

    // R4: a pending command holds with a stable channel.
    p_cmd_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a_valid && !cmd_a_ready) |=> (cmd_a_valid && $stable(cmd_a_chan)));
    p_cmd_b_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_b_valid && !cmd_b_ready) |=> (cmd_b_valid && $stable(cmd_b_chan)));

    // R5: an empty slot reports zero for the second sample.
    p_null_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && null_q) |-> (out_data_b == '0));

    // R8: a waiting result holds.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data_a) && $stable(out_data_b)));

    // R10: nothing new starts while a result waits.
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!slot_ready && !cmd_a_valid && !cmd_b_valid));
endmodule

bind dual_conv_merger dcm_checker #(
    .N_SLOTS(N_SLOTS), .CHAN_W(CHAN_W), .DATA_W(DATA_W), .TEMP_CODE(TEMP_CODE),
    .CHAN_TBL_A(CHAN_TBL_A), .NULL_MASK_B(NULL_MASK_B)
) u_dcm_checker (
    .clk(clk), .rst_n(rst_n),
    .slot_valid(slot_valid), .slot_ready(slot_ready),
    .cmd_a_valid(cmd_a_valid), .cmd_a_ready(cmd_a_ready), .cmd_a_chan(cmd_a_chan),
    .cmd_b_valid(cmd_b_valid), .cmd_b_ready(cmd_b_ready), .cmd_b_chan(cmd_b_chan),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data_a(out_data_a), .out_data_b(out_data_b),
    .null_q(null_q)
);

// File: tb/tb_dual_conv_merger.sv
module tb_dual_conv_merger;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int CW = 5;
    localparam int DW = 12;
    localparam logic [NS*CW-1:0] TA = {5'd16, 5'd2, 5'd8, 5'd5, 5'd0, 5'd3, 5'd17, 5'd1};
    localparam logic [NS*CW-1:0] TB = {5'd0, 5'd4, 5'd1, 5'd8, 5'd0, 5'd3, 5'd0, 5'd2};
    localparam logic [NS-1:0]    NM = 8'b0000_1010;

    // {idx[3], sop, eop, data_a[12], data_b[12], delay_a[4], delay_b[4], hold[4]}
    localparam logic [40:0] VEC [0:7] = '{
        {3'd0, 1'b1, 1'b0, 12'h123, 12'h456, 4'd2, 4'd3, 4'd0},
        {3'd1, 1'b0, 1'b0, 12'hABC, 12'h777, 4'd3, 4'd1, 4'd2},
        {3'd2, 1'b0, 1'b0, 12'hFFF, 12'h000, 4'd1, 4'd1, 4'd1},
        {3'd3, 1'b0, 1'b0, 12'h001, 12'hFFF, 4'd4, 4'd2, 4'd0},
        {3'd4, 1'b0, 1'b0, 12'h800, 12'h7FF, 4'd1, 4'd5, 4'd3},
        {3'd5, 1'b0, 1'b0, 12'h5A5, 12'hA5A, 4'd2, 4'd2, 4'd0},
        {3'd6, 1'b0, 1'b0, 12'h010, 12'h020, 4'd5, 4'd1, 4'd1},
        {3'd7, 1'b0, 1'b1, 12'h3FF, 12'hC00, 4'd1, 4'd4, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0, slot_sop = 1'b0, slot_eop = 1'b0;
    logic [2:0] slot_idx = '0;
    logic slot_ready;
    logic cmd_a_valid, cmd_b_valid;
    logic cmd_a_ready = 1'b1, cmd_b_ready = 1'b1;
    logic [CW-1:0] cmd_a_chan, cmd_b_chan;
    logic rsp_a_valid = 1'b0, rsp_b_valid = 1'b0;
    logic [CW-1:0] rsp_a_chan = '0, rsp_b_chan = '0;
    logic [DW-1:0] rsp_a_data = '0, rsp_b_data = '0;
    logic out_valid, out_ready = 1'b0;
    logic [2:0] out_slot;
    logic out_sop, out_eop;
    logic [CW-1:0] out_chan_a, out_chan_b;
    logic [DW-1:0] out_data_a, out_data_b;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_conv_merger #(
        .N_SLOTS(NS), .CHAN_W(CW), .DATA_W(DW), .TEMP_CODE(5'd17),
        .CHAN_TBL_A(TA), .CHAN_TBL_B(TB), .NULL_MASK_B(NM)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_idx(slot_idx),
        .slot_sop(slot_sop), .slot_eop(slot_eop),
        .cmd_a_valid(cmd_a_valid), .cmd_a_ready(cmd_a_ready), .cmd_a_chan(cmd_a_chan),
        .cmd_b_valid(cmd_b_valid), .cmd_b_ready(cmd_b_ready), .cmd_b_chan(cmd_b_chan),
        .rsp_a_valid(rsp_a_valid), .rsp_a_chan(rsp_a_chan), .rsp_a_data(rsp_a_data),
        .rsp_b_valid(rsp_b_valid), .rsp_b_chan(rsp_b_chan), .rsp_b_data(rsp_b_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
        .out_sop(out_sop), .out_eop(out_eop),
        .out_chan_a(out_chan_a), .out_data_a(out_data_a),
        .out_chan_b(out_chan_b), .out_data_b(out_data_b)
    );

    function automatic logic [CW-1:0] exp_a(input int i);
        return TA[i*CW +: CW];
    endfunction

    function automatic logic [CW-1:0] exp_b(input int i);
        return NM[i] ? {CW{1'b1}} : TB[i*CW +: CW];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic run_slot(input logic [40:0] v, input bit stall_b);
        int idx = int'(v[40:38]);
        logic [DW-1:0] da = v[35:24];
        logic [DW-1:0] db = v[23:12];
        int dla = int'(v[11:8]);
        int dlb = int'(v[7:4]);
        int hold = int'(v[3:0]);
        logic [CW-1:0] ca, cb;
        bit seen;
        @(negedge clk);
        chk(slot_ready == 1'b1, "R10", "slot_ready before offer", slot_ready, 1);
        slot_valid = 1'b1; slot_idx = v[40:38]; slot_sop = v[37]; slot_eop = v[36];
        if (stall_b) cmd_b_ready = 1'b0;
        @(negedge clk);
        slot_valid = 1'b0;
        chk(cmd_a_valid && cmd_b_valid, "R2", "both commands raised",
            {cmd_a_valid, cmd_b_valid}, 3);
        ca = cmd_a_chan; cb = cmd_b_chan;
        chk(ca == exp_a(idx), "R3", "first converter channel", ca, exp_a(idx));
        chk(cb == exp_b(idx), NM[idx] ? "R5" : "R3", "second converter channel",
            cb, exp_b(idx));
        if (stall_b) begin
            repeat (2) begin
                @(negedge clk);
                chk(!cmd_a_valid && cmd_b_valid && cmd_b_chan == cb, "R4",
                    "held second command", {cmd_a_valid, cmd_b_valid}, 1);
            end
            cmd_b_ready = 1'b1;
        end
        @(negedge clk);
        chk(!cmd_a_valid && !cmd_b_valid, "R4", "commands dropped after ready",
            {cmd_a_valid, cmd_b_valid}, 0);
        fork
            begin
                repeat (dla - 1) @(negedge clk);
                rsp_a_valid = 1'b1; rsp_a_chan = ca; rsp_a_data = da;
                @(negedge clk);
                rsp_a_valid = 1'b0;
            end
            begin
                repeat (dlb - 1) @(negedge clk);
                rsp_b_valid = 1'b1; rsp_b_chan = cb; rsp_b_data = db;
                @(negedge clk);
                rsp_b_valid = 1'b0;
            end
        join
        chk(out_valid == 1'b0, "R7", "no result one cycle after last response", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7", "result two cycles after last response", out_valid, 1);
        chk(out_slot == v[40:38] && out_sop == v[37] && out_eop == v[36], "R9",
            "slot and framing", {out_slot, out_sop, out_eop}, {v[40:38], v[37], v[36]});
        chk(out_chan_a == exp_a(idx) && out_chan_b == exp_b(idx), "R9", "channels",
            {out_chan_a, out_chan_b}, {exp_a(idx), exp_b(idx)});
        chk(out_data_a == da, "R9", "first sample", out_data_a, da);
        chk(out_data_b == (NM[idx] ? '0 : db), NM[idx] ? "R5" : "R9", "second sample",
            out_data_b, NM[idx] ? 0 : db);
        seen = 1'b0;
        for (int h = 0; h < hold; h++) begin
            slot_valid = 1'b1; slot_idx = 3'd2;
            @(negedge clk);
            chk(out_valid && out_data_a == da && out_slot == v[40:38], "R8",
                "held result", out_data_a, da);
            if (slot_ready || cmd_a_valid || cmd_b_valid) seen = 1'b1;
        end
        slot_valid = 1'b0;
        if (hold > 0)
            chk(!seen, "R10", "no new slot while result waits", seen, 0);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && slot_ready && !cmd_a_valid, "R10", "idle after result taken",
            {out_valid, slot_ready, cmd_a_valid}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(slot_ready && !cmd_a_valid && !cmd_b_valid && !out_valid, "R1",
            "reset state", {slot_ready, cmd_a_valid, cmd_b_valid, out_valid}, 8);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) run_slot(VEC[k], 1'b0);
        // Second-converter command stall on a plain slot and on an empty one.
        run_slot({3'd4, 1'b1, 1'b1, 12'h0F0, 12'h00F, 4'd2, 4'd1, 4'd1}, 1'b1);
        run_slot({3'd3, 1'b0, 1'b0, 12'h321, 12'hEEE, 4'd1, 4'd3, 4'd0}, 1'b1);
        // Temperature slot: first converter uses TEMP_CODE, second must be empty (R6).
        run_slot(VEC[1], 1'b0);
        chk(exp_a(1) == 5'd17 && NM[1], "R6", "temperature slot paired empty",
            exp_a(1), 17);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule